// File: doc/BRIEF.md
# Guarded Background Coefficient Tracker

This block keeps one correction coefficient aligned with slow drift while normal sampling continues. Each frame forms an observation window. Over that window the block adds up a signed error feature, for example the residual of each corrected sample against its expected value, and watches the raw samples for clipped codes. At the frame strobe that closes the window, the block may nudge the coefficient by the window's error sum shifted right by a programmable amount. That shift plays the role of the step size.

Updates are scheduled every programmable number of windows, or by an external event such as a temperature step. After an update, the following window acts as a verification window. If the residual magnitude grows, the coefficient returns to its previous value and the loop freezes. Clipping also freezes the loop and restores the last accepted coefficient. A freeze is released only after a programmable run of consecutive clean windows. After an event-driven update, further events are ignored for a programmable number of windows, so that a burst of triggers during a transient cannot cause repeated updates.

Top module: `cbt_coef_tracker`

## Requirements
- R1: A window consists of all cycles with `sample_valid_i` high, up to and including the cycle in which `frame_i` is high. A cycle with `sample_valid_i` low adds no error and cannot flag clipping.
- R2: An update sets the coefficient to the old coefficient plus (window error sum arithmetically shifted right by `mu_shift_i`). The result saturates to the signed range of `coef_o` and takes effect in the cycle after the closing strobe. The coefficient never changes except at a window close.
- R3: With `period_i` = P > 0, every P-th window close is a scheduled update. A scheduled close that arrives while the loop is frozen, clipped or verifying is dropped. `period_i` = 0 disables scheduling.
- R4: A valid sample equal to the most positive or the most negative code marks its window as clipped. At that window's close, the coefficient returns to the last accepted value, `frozen_o` goes high and `reason_o` becomes 1.
- R5: The window that closes right after an update verifies it. If |error sum| of that window is strictly larger than |error sum| of the window that produced the update, the coefficient reverts, `frozen_o` goes high and `reason_o` becomes 2. Otherwise the new coefficient becomes the accepted one. A verifying window never updates.
- R6: While frozen, the coefficient holds. The freeze clears at the close of the `clean_need_i`-th consecutive non-clipped window, and a clipped window restarts the count. That releasing window does not update.
- R7: A pulse on `event_i` is held pending. The next window close that is not frozen, clipped or verifying consumes it and performs an update.
- R8: An event-driven update starts a hold of `hold_i` window closes. During the hold, `event_i` pulses are discarded, and while not frozen `reason_o` reads 3.
- R9: After reset, the coefficient equals the `COEF_INIT` parameter, `frozen_o` is low and `reason_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Sample and error feature valid |
| sample_i | input | SAMPLE_W | Raw signed sample code, checked for clipping |
| err_i | input | ERR_W | Signed error feature of this sample |
| frame_i | input | 1 | Closes the current window |
| event_i | input | 1 | Event trigger pulse |
| mu_shift_i | input | MU_W | Step size as right shift of the error sum |
| period_i | input | CNT_W | Windows per scheduled update, 0 disables |
| hold_i | input | CNT_W | Windows of event hold after an event update |
| clean_need_i | input | CNT_W | Clean windows needed to release a freeze |
| coef_o | output | COEF_W | Active signed coefficient |
| frozen_o | output | 1 | Loop frozen |
| reason_o | output | 2 | 0 none, 1 clipping, 2 rollback, 3 event hold |

## Verification
Some properties are checked on every cycle. The coefficient stays put between window closes and throughout a freeze. A clipped close always leads to a clipping freeze. The reason code stays in the set allowed by the freeze state. The bench covers the behaviour that depends on history and that only its scenarios can show: the periodic count, the accept-or-revert decision of the verification window, the length of the clean run that releases a freeze, an event discarded inside the hold, the restore of the last accepted value when a verification window clips, valid gating of the sum, and saturation at the top of the coefficient range.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  typedef enum logic [1:0] {
    RSN_NONE     = 2'd0,
    RSN_CLIP     = 2'd1,
    RSN_ROLLBACK = 2'd2,
    RSN_HOLD     = 2'd3
  } rsn_e;
endpackage

// File: rtl/cbt_window_stats.sv
module cbt_window_stats #(
  parameter int SAMPLE_W = 12,
  parameter int ERR_W    = 10,
  parameter int ACC_W    = 18
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sample_valid_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic signed [ERR_W-1:0]    err_i,
  input  logic                       frame_i,
  output logic signed [ACC_W-1:0]    sum_o,
  output logic                       clip_o,
  output logic                       done_o
);
  localparam logic signed [SAMPLE_W-1:0] CODE_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [SAMPLE_W-1:0] CODE_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] add;
  logic                    clip_q;
  logic                    hit;

  assign hit    = sample_valid_i && ((sample_i == CODE_MAX) || (sample_i == CODE_MIN));
  assign add    = sample_valid_i ? ACC_W'(err_i) : '0;
  assign sum_o  = acc_q + add;
  assign clip_o = clip_q | hit;
  assign done_o = frame_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      clip_q <= 1'b0;
    end else if (frame_i) begin
      acc_q  <= '0;
      clip_q <= 1'b0;
    end else begin
      acc_q  <= sum_o;
      clip_q <= clip_o;
    end
  end
endmodule

// File: rtl/cbt_scheduler.sv
module cbt_scheduler #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic             event_i,
  input  logic             consume_evt_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] hold_i,
  output logic             due_o,
  output logic             evt_o,
  output logic             hold_o
);
  logic [CNT_W-1:0] fcnt_q;
  logic [CNT_W-1:0] gap_q;
  logic             evt_q;
  logic             wrap;

  assign wrap   = (period_i != '0) && (fcnt_q >= (period_i - CNT_W'(1)));
  assign due_o  = done_i && wrap;
  assign evt_o  = evt_q;
  assign hold_o = (gap_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt_q <= '0;
    end else if (done_i) begin
      if (period_i == '0 || wrap) fcnt_q <= '0;
      else                        fcnt_q <= fcnt_q + CNT_W'(1);
    end
  end

  // event accepted only outside the hold; a new pulse beats a same-cycle consume
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= 1'b0;
      gap_q <= '0;
    end else begin
      if (consume_evt_i)                 evt_q <= 1'b0;
      if (event_i && gap_q == '0)        evt_q <= 1'b1;
      if (consume_evt_i)                 gap_q <= hold_i;
      else if (done_i && gap_q != '0)    gap_q <= gap_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/cbt_update_core.sv
module cbt_update_core
  import cbt_pkg::*;
#(
  parameter int                         COEF_W    = 16,
  parameter int                         ACC_W     = 18,
  parameter int                         MU_W      = 4,
  parameter int                         CNT_W     = 8,
  parameter logic signed [COEF_W-1:0]   COEF_INIT = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     done_i,
  input  logic signed [ACC_W-1:0]  sum_i,
  input  logic                     clip_i,
  input  logic                     due_i,
  input  logic                     evt_i,
  input  logic [MU_W-1:0]          mu_shift_i,
  input  logic [CNT_W-1:0]         clean_need_i,
  output logic signed [COEF_W-1:0] coef_o,
  output logic                     frozen_o,
  output rsn_e                     freason_o,
  output logic                     consume_evt_o
);
  localparam int WIDE_W = ((ACC_W > COEF_W) ? ACC_W : COEF_W) + 1;
  localparam logic signed [WIDE_W-1:0] C_MAX = {{(WIDE_W-COEF_W+1){1'b0}}, {(COEF_W-1){1'b1}}};
  localparam logic signed [WIDE_W-1:0] C_MIN = {{(WIDE_W-COEF_W+1){1'b1}}, {(COEF_W-1){1'b0}}};

  logic signed [COEF_W-1:0] coef_q, good_q, coef_new;
  logic [ACC_W-1:0]         ref_q, mag;
  logic signed [ACC_W-1:0]  step, neg_sum;
  logic signed [WIDE_W-1:0] sum_wide;
  logic [CNT_W-1:0]         clean_q;
  logic [CNT_W:0]           clean_next;
  logic                     pend_q, frozen_q, eligible, release_ok;
  rsn_e                     rsn_q;

  assign neg_sum    = -sum_i;
  assign mag        = sum_i[ACC_W-1] ? neg_sum : sum_i;
  assign step       = sum_i >>> mu_shift_i;
  assign sum_wide   = WIDE_W'(coef_q) + WIDE_W'(step);
  assign clean_next = {1'b0, clean_q} + (CNT_W+1)'(1);
  assign release_ok = clean_next >= {1'b0, clean_need_i};
  assign eligible   = done_i && !clip_i && !pend_q && !frozen_q;
  assign consume_evt_o = eligible && evt_i;

  always_comb begin
    if (sum_wide > C_MAX)      coef_new = C_MAX[COEF_W-1:0];
    else if (sum_wide < C_MIN) coef_new = C_MIN[COEF_W-1:0];
    else                       coef_new = sum_wide[COEF_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coef_q   <= COEF_INIT;
      good_q   <= COEF_INIT;
      ref_q    <= '0;
      pend_q   <= 1'b0;
      frozen_q <= 1'b0;
      rsn_q    <= RSN_NONE;
      clean_q  <= '0;
    end else if (done_i) begin
      if (clip_i) begin
        coef_q   <= good_q;
        pend_q   <= 1'b0;
        frozen_q <= 1'b1;
        rsn_q    <= RSN_CLIP;
        clean_q  <= '0;
      end else if (pend_q) begin
        pend_q <= 1'b0;
        if (mag > ref_q) begin
          coef_q   <= good_q;
          frozen_q <= 1'b1;
          rsn_q    <= RSN_ROLLBACK;
          clean_q  <= '0;
        end else begin
          good_q <= coef_q;
        end
      end else if (frozen_q) begin
        if (release_ok) begin
          frozen_q <= 1'b0;
          rsn_q    <= RSN_NONE;
          clean_q  <= '0;
        end else begin
          clean_q <= clean_next[CNT_W-1:0];
        end
      end else if (due_i || evt_i) begin
        coef_q <= coef_new;
        ref_q  <= mag;
        pend_q <= 1'b1;
      end
    end
  end

  assign coef_o    = coef_q;
  assign frozen_o  = frozen_q;
  assign freason_o = rsn_q;
endmodule

// File: rtl/cbt_coef_tracker.sv
module cbt_coef_tracker
  import cbt_pkg::*;
#(
  parameter int                       SAMPLE_W  = 12,
  parameter int                       ERR_W     = 10,
  parameter int                       WIN_LOG2  = 8,
  parameter int                       COEF_W    = 16,
  parameter int                       MU_W      = 4,
  parameter int                       CNT_W     = 8,
  parameter logic signed [COEF_W-1:0] COEF_INIT = '0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sample_valid_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic signed [ERR_W-1:0]    err_i,
  input  logic                       frame_i,
  input  logic                       event_i,
  input  logic [MU_W-1:0]            mu_shift_i,
  input  logic [CNT_W-1:0]           period_i,
  input  logic [CNT_W-1:0]           hold_i,
  input  logic [CNT_W-1:0]           clean_need_i,
  output logic signed [COEF_W-1:0]   coef_o,
  output logic                       frozen_o,
  output logic [1:0]                 reason_o
);
  localparam int ACC_W = ERR_W + WIN_LOG2;

  logic signed [ACC_W-1:0] win_sum;
  logic                    win_clip, win_done;
  logic                    due, evt, hold, consume_evt;
  rsn_e                    freason;

  cbt_window_stats #(.SAMPLE_W(SAMPLE_W), .ERR_W(ERR_W), .ACC_W(ACC_W)) u_stats (
    .clk_i, .rst_ni, .sample_valid_i, .sample_i, .err_i, .frame_i,
    .sum_o(win_sum), .clip_o(win_clip), .done_o(win_done)
  );

  cbt_scheduler #(.CNT_W(CNT_W)) u_sched (
    .clk_i, .rst_ni, .done_i(win_done), .event_i, .consume_evt_i(consume_evt),
    .period_i, .hold_i, .due_o(due), .evt_o(evt), .hold_o(hold)
  );

  cbt_update_core #(
    .COEF_W(COEF_W), .ACC_W(ACC_W), .MU_W(MU_W), .CNT_W(CNT_W), .COEF_INIT(COEF_INIT)
  ) u_core (
    .clk_i, .rst_ni, .done_i(win_done), .sum_i(win_sum), .clip_i(win_clip),
    .due_i(due), .evt_i(evt), .mu_shift_i, .clean_need_i,
    .coef_o, .frozen_o, .freason_o(freason), .consume_evt_o(consume_evt)
  );

  always_comb begin
    if (frozen_o)  reason_o = freason;
    else if (hold) reason_o = RSN_HOLD;
    else           reason_o = RSN_NONE;
  end
endmodule

// File: rtl/cbt_coef_tracker_chk.sv
module cbt_coef_tracker_chk #(
  parameter int COEF_W = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     win_done,
  input logic                     win_clip,
  input logic signed [COEF_W-1:0] coef_o,
  input logic                     frozen_o,
  input logic [1:0]               reason_o
);
  AST_COEF_STABLE_MIDWIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_done |=> $stable(coef_o)); // R2
  AST_CLIP_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_done && win_clip) |=> (frozen_o && reason_o == 2'd1)); // R4
  AST_FROZEN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_o |=> $stable(coef_o)); // R6
  AST_FROZEN_REASON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_o |-> (reason_o == 2'd1 || reason_o == 2'd2)); // R5
  AST_RUN_REASON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frozen_o |-> (reason_o == 2'd0 || reason_o == 2'd3)); // R8
endmodule

bind cbt_coef_tracker cbt_coef_tracker_chk #(.COEF_W(COEF_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .win_done(win_done), .win_clip(win_clip),
  .coef_o(coef_o), .frozen_o(frozen_o), .reason_o(reason_o)
);

// File: tb/cbt_coef_tracker_test.sv
`timescale 1ns/1ps
module cbt_coef_tracker_test;
  localparam int SW = 12, EW = 10, CW = 16, MW = 4, NW = 8;
  localparam int CMAX = 32767, CMIN = -32768;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sv = 1'b0, fr = 1'b0, ev = 1'b0;
  logic signed [SW-1:0] smp = '0;
  logic signed [EW-1:0] err = '0;
  logic [MW-1:0] mu = '0;
  logic [NW-1:0] per = '0, hold = '0, cneed = '0;
  logic signed [CW-1:0] coef;
  logic frozen;
  logic [1:0] reason;

  int checks = 0, errors = 0;
  string phase = "R9";

  // reference state
  int m_acc, m_coef, m_good, m_ref, m_clean, m_fcnt, m_gap, m_freason;
  bit m_clip, m_pend, m_frozen, m_evt;

  always #4 clk = ~clk;

  cbt_coef_tracker uut (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(sv), .sample_i(smp), .err_i(err),
    .frame_i(fr), .event_i(ev), .mu_shift_i(mu), .period_i(per), .hold_i(hold),
    .clean_need_i(cneed), .coef_o(coef), .frozen_o(frozen), .reason_o(reason)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int exp_reason();
    if (m_frozen) return m_freason;
    return (m_gap != 0) ? 3 : 0;
  endfunction

  task automatic model_reset();
    m_acc = 0; m_coef = 0; m_good = 0; m_ref = 0; m_clean = 0; m_fcnt = 0; m_gap = 0;
    m_freason = 0; m_clip = 0; m_pend = 0; m_frozen = 0; m_evt = 0;
  endtask

  task automatic model_step();
    bit hit, due, elig, cons;
    int add, sum, mag, nw, old_gap;
    hit = sv && (int'(smp) == 2047 || int'(smp) == -2048);
    add = sv ? int'(err) : 0;
    old_gap = m_gap;
    cons = 0;
    if (fr) begin
      sum = m_acc + add;
      hit = hit | m_clip;
      mag = (sum < 0) ? -sum : sum;
      due = (per != 0) && (m_fcnt >= int'(per) - 1);
      elig = !hit && !m_pend && !m_frozen;
      cons = elig && m_evt;
      if (per == 0 || due) m_fcnt = 0; else m_fcnt++;
      if (hit) begin
        m_coef = m_good; m_pend = 0; m_frozen = 1; m_freason = 1; m_clean = 0;
      end else if (m_pend) begin
        m_pend = 0;
        if (mag > m_ref) begin
          m_coef = m_good; m_frozen = 1; m_freason = 2; m_clean = 0;
        end else m_good = m_coef;
      end else if (m_frozen) begin
        if (m_clean + 1 >= int'(cneed)) begin
          m_frozen = 0; m_freason = 0; m_clean = 0;
        end else m_clean++;
      end else if (due || m_evt) begin
        nw = m_coef + (sum >>> int'(mu));
        if (nw > CMAX) nw = CMAX;
        if (nw < CMIN) nw = CMIN;
        m_coef = nw; m_ref = mag; m_pend = 1;
      end
      m_acc = 0; m_clip = 0;
    end else begin
      m_acc += add; m_clip = m_clip | hit;
    end
    if (cons) m_gap = int'(hold);
    else if (fr && m_gap > 0) m_gap--;
    if (cons) m_evt = 0;
    if (ev && old_gap == 0) m_evt = 1;
  endtask

  task automatic tick(bit v, int s, int e, bit f, bit evn);
    sv = v; smp = SW'(s); err = EW'(e); fr = f; ev = evn;
    @(posedge clk);
    model_step();
    #1;
    check(phase, "coef", int'(coef), m_coef);
    check(phase, "frozen", int'(frozen), int'(m_frozen));
    check(phase, "reason", int'(reason), exp_reason());
  endtask

  task automatic window(int n, int e, bit clip_last);
    for (int i = 0; i < n; i++)
      tick(1'b1, (clip_last && i == n-1) ? 2047 : 100, e, i == n-1, 1'b0);
  endtask

  task automatic pulse_event();
    tick(1'b0, 0, 0, 1'b0, 1'b1);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R9", "reset coef", int'(coef), 0);
    check("R9", "reset frozen", int'(frozen), 0);
    check("R9", "reset reason", int'(reason), 0);
    rst_n = 1'b1;
    per = 8'd4; mu = 4'd2; hold = 8'd3; cneed = 8'd2;

    // scheduled update every fourth window, step 32>>>2
    phase = "R3";
    for (int w = 0; w < 3; w++) window(4, 8, 1'b0);
    check("R3", "no update before period", int'(coef), 0);
    window(4, 8, 1'b0);
    check("R2", "scaled step", int'(coef), 8);
    window(4, 8, 1'b0);
    check("R5", "equal residual accepted", int'(coef), 8);

    // worse residual after update rolls back
    phase = "R5";
    window(4, 8, 1'b0);
    window(4, 8, 1'b0);
    window(4, 4, 1'b0);
    check("R2", "second step", int'(coef), 12);
    window(4, 10, 1'b0);
    check("R5", "rollback coef", int'(coef), 8);
    check("R5", "rollback frozen", int'(frozen), 1);
    check("R5", "rollback reason", int'(reason), 2);

    // release after two clean windows
    phase = "R6";
    window(4, 8, 1'b0);
    check("R6", "still frozen after one clean", int'(frozen), 1);
    window(4, 8, 1'b0);
    check("R6", "released", int'(frozen), 0);

    // event-driven update, hold status
    phase = "R7";
    per = 8'd0;
    pulse_event();
    window(4, 8, 1'b0);
    check("R7", "event update", int'(coef), 16);
    check("R8", "hold reason", int'(reason), 3);
    window(4, 8, 1'b0);

    phase = "R8";
    pulse_event();
    window(4, 8, 1'b0);
    check("R8", "event in hold ignored", int'(coef), 16);
    window(4, 8, 1'b0);
    check("R8", "hold expired", int'(reason), 0);
    window(4, 8, 1'b0);
    check("R8", "no stale event", int'(coef), 16);

    // clip during verification restores last accepted value
    phase = "R4";
    pulse_event();
    window(4, 8, 1'b0);
    check("R7", "second event update", int'(coef), 24);
    window(4, 8, 1'b1);
    check("R4", "clip restores good", int'(coef), 16);
    check("R4", "clip frozen", int'(frozen), 1);
    check("R4", "clip reason", int'(reason), 1);
    phase = "R6";
    window(4, 8, 1'b0);
    window(4, 8, 1'b1);
    window(4, 8, 1'b0);
    check("R6", "clip restarted clean count", int'(frozen), 1);
    window(4, 8, 1'b0);
    check("R6", "released after clean run", int'(frozen), 0);
    check("R6", "coef held through freeze", int'(coef), 16);

    // invalid cycles neither add error nor clip
    phase = "R1";
    per = 8'd1; mu = 4'd0;
    tick(1'b1, 100, 5, 1'b0, 1'b0);
    tick(1'b0, 2047, 5, 1'b0, 1'b0);
    tick(1'b1, 100, 5, 1'b0, 1'b0);
    tick(1'b1, 100, 5, 1'b1, 1'b0);
    check("R1", "valid gated sum", int'(coef), 31);
    check("R1", "invalid max code no clip", int'(frozen), 0);
    window(3, 5, 1'b0);
    check("R1", "verify accepted", int'(coef), 31);

    // saturation at the top of the range
    phase = "R2";
    for (int k = 0; k < 10; k++) begin
      window(8, 500, 1'b0);
      window(8, 500, 1'b0);
    end
    check("R2", "saturated max", int'(coef), CMAX);
    window(8, 500, 1'b0);
    check("R2", "stays saturated", int'(coef), CMAX);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule